// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus slave (SMBus/I2C style) that gives a host access to a small bank of 8-bit configuration registers. The host reaches the bank through indexed block transfers. A write carries a starting index, a byte count and then the data bytes. The block stores each data byte at the index and then steps the index forward. A read first sets the index with a short write phase. A repeated start follows, and the block then returns a byte count and the register bytes from that index onward. The count returned is the value of a writable register inside the bank. The host does not choose it.

The block runs on a system clock that is much faster than the serial clock. It samples the serial clock and data lines through synchronizers and recognizes start, stop and clock edges from the sampled values. The data line is open drain. The block pulls the line low by raising its output-enable, and the host side models the line as the AND of all drivers. The register contents come out as one flat vector. A one-cycle write strobe marks each register that received a byte. Some fields are fixed: the upper nibble of the revision byte and the whole reserved byte.

Top module: `smb_idx_regbank`

## Requirements
- R1: The slave acknowledges the write address byte D2h and the read address byte D3h, that is 7-bit address 69h with the R/W bit in bit 0. It does not acknowledge any other address byte and keeps SDA released until the next start. Bytes sent after a wrong address change no register.
- R2: In a write, the byte after the address is the starting index N and the next byte is the count X. The block acknowledges each of the data bytes that follow and stores them at N, N+1, … up to N+X-1, moving the index on by one after each byte.
- R3: A data byte beyond the count X is not acknowledged and is not written.
- R4: After index N is set and a repeated start with D3h follows, the first byte sent is the value of the count register (index 8). Register bytes from N onward come next, and the index moves on after each byte the host acknowledges.
- R5: When the host does not acknowledge a read byte, the slave stops sending and leaves SDA released.
- R6: After reset, index 8 holds 0Fh, index 5 holds the revision value in bits 7:4 with 0 in bits 3:0, index 7 holds FFh and every other index holds 00h. Index 8 can be written.
- R7: Bits 7:4 of index 5 and all of index 7 are read-only. Writes leave them unchanged, while the writable bits of the same byte still take the new value.
- R8: A stop or a start at any point ends the transfer in progress. Bytes already received in full stay written, and a partly received byte is dropped.
- R9: An index at or beyond the number of registers is acknowledged in a write but the byte is ignored. Reads from such an index return 00h.
- R10: A write strobe pulses for one cycle, on at most one register at a time, whenever a register receives a byte. A register never changes without its strobe.
- R11: The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register contents, index i in bits i*8+7 down to i*8 |
| wr_stb_o | output | NUM_REGS | One-cycle pulse per register that received a byte |

## Verification
The bound checker watches four things on every cycle: that SDA is steady while SCL stays high, that the write strobes are one-hot or idle, that a register changes only together with its own strobe, and that the read-only fields and the count register start at their reset values. Other behaviour can only be shown through bus scenarios that the bench drives. These include whether an address is acknowledged, how bytes map to indices as the index moves on, the count byte at the start of a read, bytes refused beyond the count, aborts by stop or start partway through a byte, and out-of-range indices. The bench checks each of these against a register model of its own.

// File: rtl/smb_pkg.sv
// Shared types for the indexed block register slave.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package smb_pkg;

    // Bus-level state of the slave engine
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_RX,     // shifting a byte in from the host
        ST_RACK,   // slave drives the acknowledge bit
        ST_TX,     // shifting a byte out to the host
        ST_TACK    // host drives the acknowledge bit
    } bus_state_t;

    // Role of the next received byte
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_DATA
    } rx_phase_t;

    // Line events recovered from the sampled SCL and SDA
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

endpackage

// File: rtl/smb_line_sync.sv
// Samples SCL and SDA into the system clock domain and derives edge,
// start and stop events.
// Assumes: SCL high and low phases last several system clocks, and the
// host moves SDA only while SCL is low, except for start and stop.
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    // Event decode from current and previous sampled levels
    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_d;
        ev_o.scl_fall = ~scl_s & scl_d;
        ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev_o.sda      = sda_s;
    end

endmodule

// File: rtl/smb_regfile.sv
// Bank of 8-bit configuration registers with per-register write strobes.
// The revision nibble and the reserved byte are fixed at reset values.
// Assumes: at most one write request per cycle; indices outside the bank
// are ignored on write and read as zero.
module smb_regfile #(
    parameter int         NUM_REGS  = 14,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] CNT_RESET = 8'h0F,
    parameter int         REV_IDX   = 5,
    parameter logic [3:0] REV_ID    = 4'h2,
    parameter int         RSV_IDX   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_stb_o
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] MY_IDX  = 8'(i);
        localparam logic [7:0] RO_MASK = (i == REV_IDX) ? 8'hF0 :
                                         (i == RSV_IDX) ? 8'hFF : 8'h00;
        localparam logic [7:0] RST_VAL = (i == CNT_IDX) ? CNT_RESET :
                                         (i == REV_IDX) ? {REV_ID, 4'h0} :
                                         (i == RSV_IDX) ? 8'hFF : 8'h00;
        logic [7:0] q;
        logic       stb_q;
        logic       hit;

        assign hit = wr_en && (wr_idx == MY_IDX);

        // Store writable bits and pulse this register's strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q     <= RST_VAL;
                stb_q <= 1'b0;
            end else begin
                stb_q <= hit;
                if (hit) begin
                    q <= (q & RO_MASK) | (wr_data & ~RO_MASK);
                end
            end
        end

        assign regs_o[i*8 +: 8] = q;
        assign wr_stb_o[i]      = stb_q;
    end

    // Read multiplexer, zero outside the bank
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == 8'(k)) begin
                rd_data = regs_o[k*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/smb_slave_fsm.sv
// Byte and transfer engine: receives address, index, count and data bytes,
// drives acknowledges, and sends the count byte then register bytes on reads.
// Assumes: line events come from smb_line_sync; the index pointer keeps its
// value across a repeated start so a read can follow an index-setting write.
module smb_slave_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  line_ev_t   ev,
    input  logic [7:0] rd_data,
    input  logic [7:0] tx_count,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    bus_state_t state;
    rx_phase_t  phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] tx_sh;
    logic [7:0] idx;
    logic [7:0] remain;
    logic       go_tx;
    logic       host_ack;
    logic       byte_done;

    // A full byte is in and the clock has gone low after its last bit
    assign byte_done = (state == ST_RX) && ev.scl_fall && (bitcnt == 4'd8);

    // Main transfer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            bitcnt   <= 4'd0;
            shreg    <= 8'h00;
            tx_sh    <= 8'h00;
            idx      <= 8'h00;
            remain   <= 8'h00;
            go_tx    <= 1'b0;
            host_ack <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            bitcnt <= 4'd0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= 4'd0;
                        go_tx  <= 1'b0;
                        case (phase)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    state <= ST_RACK;
                                    go_tx <= shreg[0];
                                    tx_sh <= tx_count;
                                    phase <= PH_INDEX;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_INDEX: begin
                                idx   <= shreg;
                                phase <= PH_COUNT;
                                state <= ST_RACK;
                            end
                            PH_COUNT: begin
                                remain <= shreg;
                                phase  <= PH_DATA;
                                state  <= ST_RACK;
                            end
                            default: begin
                                if (remain != 8'h00) begin
                                    idx    <= idx + 8'd1;
                                    remain <= remain - 8'd1;
                                    state  <= ST_RACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (ev.scl_fall) begin
                        state  <= go_tx ? ST_TX : ST_RX;
                        bitcnt <= 4'd0;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state <= ST_TACK;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda;
                        if (!ev.sda) begin
                            tx_sh <= rd_data;
                            idx   <= idx + 8'd1;
                        end
                    end else if (ev.scl_fall) begin
                        state  <= host_ack ? ST_TX : ST_IDLE;
                        bitcnt <= 4'd0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register write request for an accepted data byte
    always_comb begin
        wr_en   = byte_done && (phase == PH_DATA) && (remain != 8'h00);
        wr_idx  = idx;
        wr_data = shreg;
    end

    // Open-drain drive: acknowledge or a zero data bit pulls SDA low
    always_comb begin
        sda_oe = (state == ST_RACK) || ((state == ST_TX) && !tx_sh[7]);
    end

    assign rd_idx = idx;

endmodule

// File: rtl/smb_idx_regbank.sv
// Top of the indexed block register slave: line sampling, transfer engine
// and register bank.
// Assumes: a single system clock much faster than SCL; SDA is open drain
// and is pulled low whenever sda_oe is high.
module smb_idx_regbank
    import smb_pkg::*;
#(
    parameter int         NUM_REGS    = 14,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         CNT_IDX     = 8,
    parameter logic [7:0] CNT_RESET   = 8'h0F,
    parameter int         REV_IDX     = 5,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter int         RSV_IDX     = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_stb_o
);

    line_ev_t   ev;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_idx;
    logic [7:0] wr_data;

    smb_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    smb_slave_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_data (rd_data),
        .tx_count(regs_o[CNT_IDX*8 +: 8]),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    smb_regfile #(
        .NUM_REGS (NUM_REGS),
        .CNT_IDX  (CNT_IDX),
        .CNT_RESET(CNT_RESET),
        .REV_IDX  (REV_IDX),
        .REV_ID   (REV_ID),
        .RSV_IDX  (RSV_IDX)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o),
        .wr_stb_o(wr_stb_o)
    );

endmodule

// File: rtl/smb_idx_regbank_chk.sv
// Port-level property checker for smb_idx_regbank, attached by bind.
// Assumes: SCL phases are longer than the synchronizer latency.
module smb_idx_regbank_chk #(
    parameter int         NUM_REGS  = 14,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] CNT_RESET = 8'h0F,
    parameter int         REV_IDX   = 5,
    parameter logic [3:0] REV_ID    = 4'h2,
    parameter int         RSV_IDX   = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs_o,
    input logic [NUM_REGS-1:0]   wr_stb_o
);

    // R11: SDA drive is steady while SCL stays high
    a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R10: at most one strobe at a time
    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));

    // R10: a register changes only together with its own strobe
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        a_r10_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(regs_o[i*8 +: 8]) |-> wr_stb_o[i]);
    end

    // R7: read-only fields hold their fixed values
    a_r7_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o[REV_IDX*8+4 +: 4] == REV_ID) && (regs_o[RSV_IDX*8 +: 8] == 8'hFF));

    // R6: count register comes out of reset at its reset value
    a_r6_count_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_o[CNT_IDX*8 +: 8] == CNT_RESET));

endmodule

bind smb_idx_regbank smb_idx_regbank_chk #(
    .NUM_REGS (NUM_REGS),
    .CNT_IDX  (CNT_IDX),
    .CNT_RESET(CNT_RESET),
    .REV_IDX  (REV_IDX),
    .REV_ID   (REV_ID),
    .RSV_IDX  (RSV_IDX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .regs_o  (regs_o),
    .wr_stb_o(wr_stb_o)
);

// File: tb/test_smb_idx_regbank.sv
// Bench for smb_idx_regbank: a bit-level bus host plus a register model.
module test_smb_idx_regbank;

    localparam int         CLK_PERIOD = 10;
    localparam int         QTR        = CLK_PERIOD / 4;
    localparam int         HALF       = 10;
    localparam int         WATCHDOG   = 190000;
    localparam int         NUM_REGS   = 14;
    localparam int         CNT_IDX    = 8;
    localparam int         REV_IDX    = 5;
    localparam int         RSV_IDX    = 7;
    localparam logic [3:0] REV_ID     = 4'h2;
    localparam logic [7:0] CNT_RESET  = 8'h0F;
    localparam logic [6:0] DEV_ADDR   = 7'h69;
    localparam logic [7:0] WR_ADDR    = {DEV_ADDR, 1'b0};
    localparam logic [7:0] RD_ADDR    = {DEV_ADDR, 1'b1};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  scl = 1'b1;
    logic                  sda_h = 1'b1;
    logic                  sda_line;
    logic                  sda_oe;
    logic [NUM_REGS*8-1:0] regs_o;
    logic [NUM_REGS-1:0]   wr_stb_o;

    assign sda_line = sda_h & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_idx_regbank i_smb_idx_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .regs_o  (regs_o),
        .wr_stb_o(wr_stb_o)
    );

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] exp_q [NUM_REGS];
    int         exp_stb [NUM_REGS];
    int         stb_seen [NUM_REGS];
    logic [7:0] wbuf [8];
    int         r11_viol = 0;
    logic       scl_prev = 1'b1;
    logic       oe_prev = 1'b0;

    // ---------------- model ----------------
    function automatic logic [7:0] ro_mask(input int i);
        return (i == REV_IDX) ? 8'hF0 : (i == RSV_IDX) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] rst_val(input int i);
        return (i == CNT_IDX) ? CNT_RESET : (i == REV_IDX) ? {REV_ID, 4'h0} :
               (i == RSV_IDX) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input int i);
        return (i < NUM_REGS) ? exp_q[i] : 8'h00;
    endfunction

    task automatic model_write(input int i, input logic [7:0] v);
        if (i < NUM_REGS) begin
            exp_q[i]   = (exp_q[i] & ro_mask(i)) | (v & ~ro_mask(i));
            exp_stb[i] = exp_stb[i] + 1;
        end
    endtask

    task automatic check(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic check_bank(input string req);
        int bad = -1;
        @(negedge clk);
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (regs_o[i*8 +: 8] !== exp_q[i]) bad = i;
        end
        n_checks++;
        if (bad >= 0) begin
            n_errors++;
            $display("FAIL %s register %0d: actual %0h expected %0h", req, bad,
                     regs_o[bad*8 +: 8], exp_q[bad]);
        end
    endtask

    // ---------------- monitors ----------------
    always @(negedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_stb_o[i]) stb_seen[i] = stb_seen[i] + 1;
        end
        if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) r11_viol++;
        scl_prev = scl;
        oe_prev  = sda_oe;
    end

    // ---------------- bus host ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #(QTR);
    endtask

    task automatic bus_start;
        sda_h = 1'b1; tick(HALF);
        scl   = 1'b1; tick(HALF);
        sda_h = 1'b0; tick(HALF);
        scl   = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop;
        sda_h = 1'b0; tick(HALF);
        scl   = 1'b1; tick(HALF);
        sda_h = 1'b1; tick(HALF);
    endtask

    task automatic clock_bit(output logic seen);
        tick(HALF);
        scl = 1'b1;
        tick(HALF/2);
        @(negedge clk);
        seen = sda_line;
        tick(HALF/2);
        scl = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i >= 8 - n; i--) begin
            sda_h = b[i];
            clock_bit(s);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        send_bits(b, 8);
        sda_h = 1'b1;
        clock_bit(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(s);
            b[i] = s;
        end
        sda_h = ~give_ack;
        clock_bit(s);
        sda_h = 1'b1;
    endtask

    task automatic do_write(input int index, input int cnt, input int nsent, input string req);
        logic a;
        bus_start;
        send_byte(WR_ADDR, a);     check("R1", "write address ack", a, 1);
        send_byte(8'(index), a);   check(req, "index ack", a, 1);
        send_byte(8'(cnt), a);     check(req, "count ack", a, 1);
        for (int k = 0; k < nsent; k++) begin
            send_byte(wbuf[k], a);
            if (k < cnt) begin
                check(req, "data ack", a, 1);
                model_write((index + k) % 256, wbuf[k]);
            end else begin
                check("R3", "ack beyond count", a, 0);
            end
        end
        bus_stop;
        check_bank(req);
    endtask

    task automatic do_read(input int index, input int n, input string req);
        logic       a;
        logic [7:0] b;
        bus_start;
        send_byte(WR_ADDR, a);   check("R1", "write address ack", a, 1);
        send_byte(8'(index), a); check(req, "read index ack", a, 1);
        bus_start;
        send_byte(RD_ADDR, a);   check("R1", "read address ack", a, 1);
        recv_byte(1'b1, b);      check("R4", "count byte", b, exp_q[CNT_IDX]);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(req, "read data", b, exp_read((index + k) % 256));
        end
        tick(4);
        @(negedge clk);
        check("R5", "SDA released after host NACK", sda_oe, 0);
        bus_stop;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic       a;
        logic [7:0] b;
        void'($urandom(32'h5EED));
        for (int i = 0; i < NUM_REGS; i++) begin
            exp_q[i] = rst_val(i); exp_stb[i] = 0; stb_seen[i] = 0;
        end
        tick(6);
        rst_n = 1'b1;
        tick(4);

        // R6 / R7 reset values
        check_bank("R6");
        check("R6", "idle sda_oe", sda_oe, 0);

        // R2 directed write and R4 read back
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        do_write(1, 3, 3, "R2");
        do_read(1, 3, "R4");

        // R6 count register writable; read returns its value first
        wbuf[0] = 8'h03;
        do_write(CNT_IDX, 1, 1, "R6");
        do_read(0, 2, "R6");

        // R7 read-only bits across 5..7
        wbuf[0] = 8'hAB; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
        do_write(REV_IDX, 3, 3, "R7");
        do_read(REV_IDX, 3, "R7");

        // R3 byte beyond count
        wbuf[0] = 8'h5A; wbuf[1] = 8'hE7;
        do_write(3, 1, 2, "R3");

        // R1 wrong address: no ack, following bytes ignored
        bus_start;
        send_byte(8'hA4, a); check("R1", "foreign address nack", a, 0);
        send_byte(8'h00, a); check("R1", "byte after foreign address", a, 0);
        send_byte(8'h01, a); check("R1", "second byte after foreign address", a, 0);
        send_byte(8'h77, a); check("R1", "third byte after foreign address", a, 0);
        bus_stop;
        check_bank("R1");

        // R8 stop partway through a byte keeps completed bytes
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h09, a); send_byte(8'h04, a);
        send_byte(8'h11, a); model_write(9, 8'h11);
        send_byte(8'h22, a); model_write(10, 8'h22);
        send_bits(8'hFF, 4);
        bus_stop;
        check_bank("R8");

        // R8 unexpected start partway through a byte
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h0B, a); send_byte(8'h03, a);
        send_byte(8'h6D, a); model_write(11, 8'h6D);
        send_bits(8'h00, 5);
        bus_start;
        send_byte(RD_ADDR, a); check("R8", "read after abort ack", a, 1);
        recv_byte(1'b1, b);    check("R8", "count after abort", b, exp_q[CNT_IDX]);
        recv_byte(1'b0, b);    check("R8", "index kept after abort", b, exp_read(12));
        bus_stop;
        check_bank("R8");

        // R9 out-of-range indices
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
        do_write(NUM_REGS - 2, 3, 3, "R9");
        do_read(NUM_REGS - 2, 3, "R9");
        wbuf[0] = 8'hEE;
        do_write(200, 1, 1, "R9");

        // Random write / read-back pairs
        for (int t = 0; t < 18; t++) begin
            int idx = $urandom_range(0, 15);
            int cnt = $urandom_range(1, 4);
            for (int k = 0; k < cnt; k++) wbuf[k] = 8'($urandom);
            do_write(idx, cnt, cnt, "R2");
            do_read(idx, cnt, "R4");
        end

        // R10 strobe counts, R11 SDA discipline
        for (int i = 0; i < NUM_REGS; i++) begin
            check("R10", $sformatf("strobe count reg %0d", i), stb_seen[i], exp_stb[i]);
        end
        check("R11", "SDA changes while SCL high", r11_viol, 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule